// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block chooses which of nine interrupt request lines a small 8-bit core services next. Each line has its own enable bit, and one global enable bit gates all of them. Each line is given one of four priority levels. That level is built from one bit in a "low" priority register and one bit in a "high" priority register. The block registers the winning request as a grant, which holds a valid strobe, a source index and a level. The grant stays on the outputs until the core acknowledges it.

On acknowledge, the level of the grant is recorded in a four-bit in-service mask. A return-from-interrupt pulse from the core retires the highest recorded level. While a handler runs, only a request at a strictly higher level can raise a new grant, so handlers nest by level. Software reaches the enable, priority and in-service state through a small address/data register port.

Source indices: 0 external 0 (edge), 1 timer 0, 2 external 1 (edge), 3 timer 1, 4 UART, 5 SPI, 6 keyboard, 7 USB, 8 smart card. All sources other than 0 and 2 are level type.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset there is no grant (`irq_valid_o` = 0), and every register reads 0: enables, global enable, both priority registers and the in-service mask.
- R2: Bits [8:0] at address 0 are the per-source enables, where bit i belongs to source i. A source whose enable bit is 0 is never granted.
- R3: Bit 15 at address 0 is the global enable. While it is 0, no grant is raised, whatever the per-source enables hold.
- R4: Bit i at address 1 is the low priority bit of source i, and bit i at address 2 is its high bit. The level of source i is {high,low}: 0 is lowest and 3 is highest. `irq_lvl_o` reports the level of the granted source.
- R5: When eligible requests of different levels are pending, the one with the highest level is granted.
- R6: When several eligible requests share the highest level, the one with the lowest source index is granted.
- R7: While the in-service mask is non-empty, only a request whose level is strictly above the highest in-service level can be granted. An equal or lower level waits, and nothing preempts level 3.
- R8: An acknowledge of a grant sets the bit of the granted level in the in-service mask. A return pulse clears the highest set bit. The mask reads as bits [3:0] at address 3.
- R9: A grant keeps `irq_valid_o` high and keeps its index and level unchanged until `irq_ack_i` is sampled high.
- R10: Edge sources (0 and 2) latch a rising request even after the line drops, and the latched request clears on acknowledge. Level sources follow their input line.
- R11: A request edge, or a register write, is sampled at one clock edge, and the resulting grant appears at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 9 | Interrupt request lines, one per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_valid_o | output | 1 | A grant is being presented |
| irq_idx_o | output | 4 | Source index of the grant |
| irq_lvl_o | output | 2 | Priority level of the grant |
| irq_ack_i | input | 1 | Core takes the presented grant |
| irq_reti_i | input | 1 | Core returns from the current handler |

## Verification
Two clock edges pass from a request or register write to its grant: the first captures it, and the second registers the arbitration result. The bench checks this for both an enable write and an edge pulse. It samples one falling edge after the capture edge, where the grant must still be absent, and then one falling edge later, where it must be present. Acknowledge and return take effect at the single edge on which they are high. So the in-service readback and the "no grant" checks are made at the falling edge after that edge. The blocking checks wait a further three to four cycles, which is longer than the two-edge grant latency. A scoreboard queue records the expected grant before the event that should cause it. A falling-edge monitor pops one entry per new grant.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int LVL_W = 2;
  localparam int NLVL  = 1 << LVL_W;

  typedef logic [LVL_W-1:0] lvl_t;

  // highest set bit of an in-service mask
  function automatic lvl_t top_lvl(input logic [NLVL-1:0] m);
    lvl_t r;
    r = '0;
    for (int i = 0; i < NLVL; i++)
      if (m[i]) r = lvl_t'(i);
    return r;
  endfunction
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int          N_SRC     = 9,
  parameter logic [8:0]  EDGE_MASK = 9'b000000101
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (EDGE_MASK[g]) begin : g_edge
      logic req_q, pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          req_q  <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          req_q <= req_i[g];
          if (req_i[g] && !req_q) pend_q <= 1'b1;
          else if (clr_i[g])      pend_q <= 1'b0;
        end
      end
      assign pend_o[g] = pend_q;
    end else begin : g_level
      logic pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= 1'b0;
        else         pend_q <= req_i[g] && !clr_i[g];
      end
      assign pend_o[g] = pend_q;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_nest_pkg::*;
#(
  parameter int N_SRC = 9,
  parameter int IDX_W = 4
) (
  input  logic             gie_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] prio_lo_i,
  input  logic [N_SRC-1:0] prio_hi_i,
  input  logic             cur_valid_i,
  input  lvl_t             cur_lvl_i,
  output logic             win_valid_o,
  output logic [IDX_W-1:0] win_idx_o,
  output lvl_t             win_lvl_o
);
  // descending scan with >= keeps the lowest index on a tie
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_lvl_o   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (gie_i && en_i[i] && pend_i[i]
          && (!cur_valid_i || lvl_t'({prio_hi_i[i], prio_lo_i[i]}) > cur_lvl_i)
          && (!win_valid_o || lvl_t'({prio_hi_i[i], prio_lo_i[i]}) >= win_lvl_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_lvl_o   = lvl_t'({prio_hi_i[i], prio_lo_i[i]});
      end
    end
  end
endmodule

// File: rtl/irq_isr_stack.sv
module irq_isr_stack
  import irq_nest_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  lvl_t            push_lvl_i,
  input  logic            pop_i,
  output logic [NLVL-1:0] mask_o,
  output logic            cur_valid_o,
  output lvl_t            cur_lvl_o
);
  logic [NLVL-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (pop_i && |mask_q) mask_d[top_lvl(mask_q)] = 1'b0;
    if (push_i)           mask_d[push_lvl_i]      = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_o      = mask_q;
  assign cur_valid_o = |mask_q;
  assign cur_lvl_o   = top_lvl(mask_q);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int         N_SRC     = 9,
  parameter int         IDX_W     = 4,
  parameter int         ADDR_W    = 2,
  parameter int         DATA_W    = 16,
  parameter logic [8:0] EDGE_MASK = 9'b000000101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_valid_o,
  output logic [IDX_W-1:0]  irq_idx_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  input  logic              irq_ack_i,
  input  logic              irq_reti_i
);
  localparam int GIE_BIT = DATA_W - 1;
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PLO = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PHI = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ISR = ADDR_W'(3);

  logic [N_SRC-1:0] en_q, prio_lo_q, prio_hi_q, pend, clr;
  logic             gie_q;
  logic [NLVL-1:0]  isr_q;
  logic             cur_valid, win_valid, valid_q, take;
  lvl_t             cur_lvl, win_lvl, lvl_q;
  logic [IDX_W-1:0] win_idx, idx_q;
  logic [DATA_W-2-N_SRC:0] unused_wdata;

  assign unused_wdata = reg_wdata_i[DATA_W-2:N_SRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= '0;
      gie_q     <= 1'b0;
      prio_lo_q <= '0;
      prio_hi_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_EN: begin
          en_q  <= reg_wdata_i[N_SRC-1:0];
          gie_q <= reg_wdata_i[GIE_BIT];
        end
        A_PLO:   prio_lo_q <= reg_wdata_i[N_SRC-1:0];
        A_PHI:   prio_hi_q <= reg_wdata_i[N_SRC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_EN: begin
        reg_rdata_o[N_SRC-1:0] = en_q;
        reg_rdata_o[GIE_BIT]   = gie_q;
      end
      A_PLO:   reg_rdata_o[N_SRC-1:0] = prio_lo_q;
      A_PHI:   reg_rdata_o[N_SRC-1:0] = prio_hi_q;
      A_ISR:   reg_rdata_o[NLVL-1:0]  = isr_q;
      default: ;
    endcase
  end

  assign take = valid_q && irq_ack_i;

  always_comb begin
    clr = '0;
    if (take) clr[idx_q] = 1'b1;
  end

  irq_pending #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (irq_req_i),
    .clr_i (clr),
    .pend_o(pend)
  );

  irq_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .gie_i      (gie_q),
    .en_i       (en_q),
    .pend_i     (pend),
    .prio_lo_i  (prio_lo_q),
    .prio_hi_i  (prio_hi_q),
    .cur_valid_i(cur_valid),
    .cur_lvl_i  (cur_lvl),
    .win_valid_o(win_valid),
    .win_idx_o  (win_idx),
    .win_lvl_o  (win_lvl)
  );

  irq_isr_stack u_isr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (take),
    .push_lvl_i (lvl_q),
    .pop_i      (irq_reti_i),
    .mask_o     (isr_q),
    .cur_valid_o(cur_valid),
    .cur_lvl_o  (cur_lvl)
  );

  // grant register: loads when idle, holds until acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      lvl_q   <= '0;
    end else if (take) begin
      valid_q <= 1'b0;
    end else if (!valid_q && win_valid) begin
      valid_q <= 1'b1;
      idx_q   <= win_idx;
      lvl_q   <= win_lvl;
    end
  end

  assign irq_valid_o = valid_q;
  assign irq_idx_o   = idx_q;
  assign irq_lvl_o   = lvl_q;
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk
  import irq_nest_pkg::*;
#(
  parameter int N_SRC = 9,
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_valid_o,
  input logic [IDX_W-1:0] irq_idx_o,
  input lvl_t             irq_lvl_o,
  input logic             irq_ack_i,
  input logic [N_SRC-1:0] en_q,
  input logic             gie_q,
  input logic [NLVL-1:0]  isr_q
);
  assert_grant_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o && !irq_ack_i |=> irq_valid_o && $stable(irq_idx_o) && $stable(irq_lvl_o));

  assert_grant_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_valid_o) |-> ((($past(en_q) >> irq_idx_o) & N_SRC'(1)) != '0));

  assert_grant_gie_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_valid_o) |-> $past(gie_q));

  assert_preempt_higher_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_valid_o) |-> ($past(isr_q) == '0 || irq_lvl_o > top_lvl($past(isr_q))));

  assert_ack_marks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o && irq_ack_i |=> (((isr_q >> $past(irq_lvl_o)) & NLVL'(1)) != '0));
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_valid_o(irq_valid_o),
  .irq_idx_o  (irq_idx_o),
  .irq_lvl_o  (irq_lvl_o),
  .irq_ack_i  (irq_ack_i),
  .en_q       (en_q),
  .gie_q      (gie_q),
  .isr_q      (isr_q)
);

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    idx;
    int    lvl;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  req = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        valid;
  logic [3:0]  idx;
  logic [1:0]  lvl;
  logic        ack = 1'b0;
  logic        reti = 1'b0;

  int   n_chk = 0;
  int   n_fail = 0;
  exp_t sb[$];
  logic prev_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_nest_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_valid_o(valid), .irq_idx_o(idx), .irq_lvl_o(lvl),
    .irq_ack_i(ack), .irq_reti_i(reti)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(string tag, logic [1:0] a, int exp);
    addr = a;
    #1;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic push(int i, int l, string tag);
    exp_t e;
    e.idx = i; e.lvl = l; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_grant();
    for (int k = 0; k < 20; k++) begin
      if (valid) break;
      @(negedge clk);
    end
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1; @(negedge clk); reti = 1'b0;
  endtask

  task automatic finish_run();
    chk("scoreboard drained", sb.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: one scoreboard entry per new grant
  always @(negedge clk) begin
    if (rst_n && valid && !prev_valid) begin
      if (sb.size() == 0) begin
        chk("unexpected grant idx", int'(idx), -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " idx"}, int'(idx), e.idx);
        chk({e.tag, " lvl"}, int'(lvl), e.lvl);
      end
    end
    prev_valid = valid;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(2);
    // R1 reset state
    chk("R1 valid", int'(valid), 0);
    rd("R1 en", 2'd0, 0);
    rd("R1 plo", 2'd1, 0);
    rd("R1 phi", 2'd2, 0);
    rd("R1 isr", 2'd3, 0);
    rst_n = 1'b1;

    // R6 tie at level 0, R9 hold, R7 equal level waits, R8 mask
    wr(2'd0, 16'h81FF);
    rd("R2 en readback", 2'd0, 16'h81FF);
    push(1, 0, "R6 tie");
    req[1] = 1'b1; req[4] = 1'b1;
    wait_grant();
    tick(3);
    chk("R9 held valid", int'(valid), 1);
    chk("R9 held idx", int'(idx), 1);
    do_ack();
    req[1] = 1'b0;
    rd("R8 isr after ack", 2'd3, 1);
    tick(4);
    chk("R7 equal level waits", int'(valid), 0);
    push(4, 0, "R7 after return");
    do_reti();
    wait_grant();
    do_ack(); req[4] = 1'b0; do_reti();
    rd("R8 isr after return", 2'd3, 0);

    // R4 levels: 3->1, 5->3, 7->2, 8->3
    wr(2'd1, 16'h0128);
    wr(2'd2, 16'h01A0);
    rd("R4 plo", 2'd1, 16'h0128);
    push(7, 2, "R5 higher level");
    req[3] = 1'b1; req[7] = 1'b1;
    wait_grant();
    do_ack(); req[7] = 1'b0;
    rd("R8 isr lvl2", 2'd3, 4);
    push(5, 3, "R7 preempt");
    req[5] = 1'b1;
    wait_grant();
    do_ack(); req[5] = 1'b0;
    rd("R8 isr nested", 2'd3, 12);
    req[8] = 1'b1;
    tick(4);
    chk("R7 level3 not preempted", int'(valid), 0);
    push(8, 3, "R7 after level3 return");
    do_reti();
    wait_grant();
    do_ack(); req[8] = 1'b0;
    do_reti();
    rd("R8 reti clears top", 2'd3, 4);
    tick(3);
    chk("R7 lower level waits", int'(valid), 0);
    push(3, 1, "R4 level1");
    do_reti();
    wait_grant();
    do_ack(); req[3] = 1'b0; do_reti();
    rd("R8 isr empty", 2'd3, 0);

    // R2 disabled source, R11 write latency
    wr(2'd0, 16'h81BF);
    req[6] = 1'b1;
    tick(4);
    chk("R2 disabled not taken", int'(valid), 0);
    push(6, 0, "R11 after enable");
    wr(2'd0, 16'h81FF);
    chk("R11 not yet", int'(valid), 0);
    tick(1);
    chk("R11 grant due", int'(valid), 1);
    do_ack(); req[6] = 1'b0; do_reti();

    // R3 global enable
    wr(2'd0, 16'h01FF);
    req[1] = 1'b1;
    tick(4);
    chk("R3 gie off", int'(valid), 0);
    push(1, 0, "R3 gie on");
    wr(2'd0, 16'h81FF);
    wait_grant();
    do_ack(); req[1] = 1'b0; do_reti();

    // R10 edge source latches a one-cycle pulse, R11 request latency
    push(0, 0, "R10 edge latch");
    tick(1);
    req[0] = 1'b1;
    tick(1);
    chk("R11 req not yet", int'(valid), 0);
    req[0] = 1'b0;
    tick(1);
    chk("R10 pulse granted", int'(valid), 1);
    do_ack(); do_reti();
    tick(4);
    chk("R10 cleared on ack", int'(valid), 0);

    finish_run();
  end
endmodule